// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This block keeps time as a count of elapsed seconds in a retained power domain. A one-cycle pulse on `tick` marks each second. On every such pulse the block raises an up counter and lowers a companion down counter. Software loads the two counters as complements, so their sum stays at all ones. Two alarm compare registers watch the up count. A hit sets a sticky status bit, which can raise an interrupt line and can drive a wake output that powers the system on.

Software reaches every register through a simple 32-bit register bus. A write completes on the clock edge where `bus_en` and `bus_we` are both high. A read is combinational from `bus_addr`. A marker register holds a magic word once firmware has set the clock up. A small scratch RAM keeps data across system power cycles. A bus reset returns only the control and status state to zero. The counters, compare registers, marker and RAM keep their contents, as they would in the always-on domain.

Top module: `sec_rtc`

## Requirements
- R1: On a clock edge with `tick` high and control bit 6 clear, the up count (offset 0x00) rises by one and the down count (offset 0x04) falls by one, both wrapping modulo 2^32.
- R2: While control bit 6 (offset 0x10) is set, ticks leave both counters unchanged. Bus writes to offsets 0x00 and 0x04 load them in any mode.
- R3: At a tick edge where the up count after that tick equals compare register A (0x08) or B (0x0C), status bit 0 or bit 1 (offset 0x14) is set. It is set again on every later tick for which the equality still holds, including while counting is held.
- R4: Status bits are sticky. Writing 1 to a bit at 0x14 clears it and writing 0 leaves it alone. A set in the same cycle wins over the clear.
- R5: `irq` is high when (status bit 0 and control bit 0) or (status bit 1 and control bit 1).
- R6: `wake` is high when control bit 7 is set, or (status bit 0 and control bit 2), or (status bit 1 and control bit 3). Status bit 2 is set when a compare hit occurs whose wake enable (bit 2 for A, bit 3 for B) is set.
- R7: While control bit 4 is set, both counters and all status bits are forced to zero and ticks have no effect.
- R8: The marker register at 0x18 holds any 32-bit value written to it. The value 0xB5C13F27 denotes an initialised clock.
- R9: A bus reset clears the control register and status. It keeps the counters, the compare registers, the marker and the scratch RAM.
- R10: The scratch RAM holds 32 words of 32 bits at offsets 0x80 to 0xFC.
- R11: Offsets 0x1C to 0x7C read zero and writes to them change nothing. Control bit 5 is not implemented and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low bus reset (control and status only) |
| tick | input | 1 | One-cycle pulse once per second |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Alarm interrupt request |
| wake | output | 1 | Power-on switch drive |

## Verification
A bus write lands on the rising edge that samples it, and its effect can be read back straight after that edge. A tick changes the counters and the status bits on that same edge. `irq` and `wake` are decoded from registered state, so they follow on that edge, with no further cycle of delay. The control-bit-4 clear acts one edge after the write that sets the bit. The bench drives every input on the falling edge and reads or samples outputs one nanosecond later. Each result is therefore observed after exactly the edges that produce it, and never on an edge.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
    localparam int NUM_MATCH = 2;
    localparam int CTL_W     = 8;

    // word offsets (byte offset / 4); software depends on these positions
    localparam int OFS_UP     = 0;
    localparam int OFS_DN     = 1;
    localparam int OFS_MATCH0 = 2;
    localparam int OFS_CTL    = 4;
    localparam int OFS_STAT   = 5;
    localparam int OFS_KEY    = 6;

    // control bit positions
    localparam int CTL_IRQ0   = 0;
    localparam int CTL_WAKE0  = 2;
    localparam int CTL_CLR    = 4;
    localparam int CTL_HOLD   = 6;
    localparam int CTL_FORCE  = 7;
    localparam logic [CTL_W-1:0] CTL_MASK = 8'hDF;

    localparam logic [31:0] KEY_MAGIC = 32'hB5C1_3F27;
endpackage

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         hold,
    input  logic         clr,
    input  logic         ld_up,
    input  logic         ld_dn,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] up,
    output logic [W-1:0] dn,
    output logic [W-1:0] up_next
);
    typedef struct packed {
        logic [W-1:0] up;
        logic [W-1:0] dn;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic adv;

    always_comb begin
        adv     = tick & ~hold;
        up_next = adv ? cnt_q.up + W'(1) : cnt_q.up;
        cnt_d   = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else begin
            if (adv) begin
                cnt_d.up = cnt_q.up + W'(1);
                cnt_d.dn = cnt_q.dn - W'(1);
            end
            if (ld_up) cnt_d.up = ld_val;
            if (ld_dn) cnt_d.dn = ld_val;
        end
    end

    // retained domain: no bus reset on the counters
    always_ff @(posedge clk) cnt_q <= cnt_d;

    assign up = cnt_q.up;
    assign dn = cnt_q.dn;

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold && !clr && !ld_up && !ld_dn)
        |=> (up == $past(up) + W'(1)) && (dn == $past(dn) - W'(1))); // R1
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr && !ld_up && !ld_dn) |=> $stable(up) && $stable(dn)); // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (up == '0) && (dn == '0)); // R7
endmodule

// File: rtl/sec_rtc_status.sv
module sec_rtc_status #(
    parameter int W  = 32,
    parameter int NM = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 clr,
    input  logic [W-1:0]         up_next,
    input  logic [NM-1:0][W-1:0] match,
    input  logic [NM-1:0]        irq_en,
    input  logic [NM-1:0]        wake_en,
    input  logic                 force_wake,
    input  logic [NM:0]          w1c,
    output logic [NM:0]          stat,
    output logic                 irq,
    output logic                 wake
);
    logic [NM-1:0] hit;
    logic [NM:0]   stat_d, stat_q;

    for (genvar g = 0; g < NM; g++) begin : g_cmp
        assign hit[g] = tick && (up_next == match[g]);

        AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && !clr) |=> stat[g]); // R3
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[g] && !w1c[g] && !clr) |=> stat[g]); // R4
    end

    always_comb begin
        stat_d           = stat_q & ~w1c;
        stat_d[NM-1:0]   = stat_d[NM-1:0] | hit;
        if (|(hit & wake_en)) stat_d[NM] = 1'b1;
        if (clr) stat_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;
    assign irq  = |(stat_q[NM-1:0] & irq_en);
    assign wake = force_wake | (|(stat_q[NM-1:0] & wake_en));

    AST_WAKE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(hit & wake_en)) && !clr) |=> stat[NM]); // R6
endmodule

// File: rtl/sec_rtc_scratch.sv
module sec_rtc_scratch #(
    parameter int W     = 32,
    parameter int WORDS = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int W         = 32,
    parameter int ADDR_W    = 8,
    parameter int RAM_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq,
    output logic              wake
);
    localparam int RAM_AW = $clog2(RAM_WORDS);
    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [CTL_W-1:0]                ctrl;
        logic [NUM_MATCH-1:0][W-1:0]     match;
        logic [W-1:0]                    key;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                 wr, in_ram;
    logic [WIDX_W-1:0]    widx;
    logic [W-1:0]         up, dn, up_next, ram_rdata;
    logic [NUM_MATCH:0]   stat, w1c;

    assign wr     = bus_en & bus_we;
    assign in_ram = bus_addr[ADDR_W-1];
    assign widx   = bus_addr[ADDR_W-1:2];

    always_comb begin
        regs_d = regs_q;
        w1c    = '0;
        if (wr && !in_ram) begin
            if (widx == WIDX_W'(OFS_CTL))  regs_d.ctrl = bus_wdata[CTL_W-1:0] & CTL_MASK;
            if (widx == WIDX_W'(OFS_KEY))  regs_d.key  = bus_wdata;
            if (widx == WIDX_W'(OFS_STAT)) w1c         = bus_wdata[NUM_MATCH:0];
            for (int g = 0; g < NUM_MATCH; g++) begin
                if (widx == WIDX_W'(OFS_MATCH0 + g)) regs_d.match[g] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q.match <= regs_d.match;
        regs_q.key   <= regs_d.key;
        if (!rst_n) regs_q.ctrl <= '0;
        else        regs_q.ctrl <= regs_d.ctrl;
    end

    sec_rtc_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .hold    (regs_q.ctrl[CTL_HOLD]),
        .clr     (regs_q.ctrl[CTL_CLR]),
        .ld_up   (wr && !in_ram && widx == WIDX_W'(OFS_UP)),
        .ld_dn   (wr && !in_ram && widx == WIDX_W'(OFS_DN)),
        .ld_val  (bus_wdata),
        .up      (up),
        .dn      (dn),
        .up_next (up_next)
    );

    sec_rtc_status #(.W(W), .NM(NUM_MATCH)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .clr        (regs_q.ctrl[CTL_CLR]),
        .up_next    (up_next),
        .match      (regs_q.match),
        .irq_en     (regs_q.ctrl[CTL_IRQ0 +: NUM_MATCH]),
        .wake_en    (regs_q.ctrl[CTL_WAKE0 +: NUM_MATCH]),
        .force_wake (regs_q.ctrl[CTL_FORCE]),
        .w1c        (w1c),
        .stat       (stat),
        .irq        (irq),
        .wake       (wake)
    );

    sec_rtc_scratch #(.W(W), .WORDS(RAM_WORDS)) u_ram (
        .clk   (clk),
        .we    (wr && in_ram),
        .addr  (bus_addr[2 +: RAM_AW]),
        .wdata (bus_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_ram) begin
            bus_rdata = ram_rdata;
        end else begin
            case (widx)
                WIDX_W'(OFS_UP):         bus_rdata = up;
                WIDX_W'(OFS_DN):         bus_rdata = dn;
                WIDX_W'(OFS_MATCH0):     bus_rdata = regs_q.match[0];
                WIDX_W'(OFS_MATCH0 + 1): bus_rdata = regs_q.match[1];
                WIDX_W'(OFS_CTL):        bus_rdata = W'(regs_q.ctrl);
                WIDX_W'(OFS_STAT):       bus_rdata = W'(stat);
                WIDX_W'(OFS_KEY):        bus_rdata = regs_q.key;
                default:                 bus_rdata = '0;
            endcase
        end
    end

    AST_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !in_ram && widx == WIDX_W'(OFS_KEY)) |=> (regs_q.key == $past(bus_wdata))); // R8
endmodule

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    sec_rtc u_sec_rtc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #1 v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic pins(input string tag, input logic exp_irq, input logic exp_wake);
        @(negedge clk); #1;
        chk({tag, " irq"}, 32'(irq), 32'(exp_irq));
        chk({tag, " wake"}, 32'(wake), 32'(exp_wake));
    endtask

    task automatic t_reset_state();
        rdchk("R9 ctrl after reset", 8'h10, 32'h0);
        rdchk("R9 status after reset", 8'h14, 32'h0);
        pins("R9 reset", 1'b0, 1'b0);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_count();
        wr(8'h10, 32'h40);
        wr(8'h00, 32'd5);
        wr(8'h04, ~32'd5);
        pulse_tick(); pulse_tick();
        rdchk("R2 up held", 8'h00, 32'd5);
        rdchk("R2 down held", 8'h04, ~32'd5);
        wr(8'h10, 32'h0);
        for (int i = 0; i < 3; i++) pulse_tick();
        rdchk("R1 up after 3 ticks", 8'h00, 32'd8);
        rdchk("R1 down after 3 ticks", 8'h04, ~32'd8);
    endtask

    task automatic t_wrap();
        wr(8'h10, 32'h40);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
        wr(8'h10, 32'h0);
        pulse_tick();
        rdchk("R1 up wraps", 8'h00, 32'h0);
        rdchk("R1 down wraps", 8'h04, 32'hFFFF_FFFF);
        rdchk("R3 no false hit at wrap", 8'h14, 32'h0);
    endtask

    task automatic t_match_irq();
        wr(8'h10, 32'h40);
        wr(8'h00, 32'd10);
        wr(8'h04, ~32'd10);
        wr(8'h08, 32'd12);
        wr(8'h10, 32'h01);
        pulse_tick();
        rdchk("R3 no hit at 11", 8'h14, 32'h0);
        pins("R5 idle", 1'b0, 1'b0);
        pulse_tick();
        rdchk("R3 up at 12", 8'h00, 32'd12);
        rdchk("R3 hit A", 8'h14, 32'h1);
        pins("R5 irq on hit", 1'b1, 1'b0);
        wr(8'h14, 32'h2);
        rdchk("R4 write 0 keeps bit", 8'h14, 32'h1);
        wr(8'h14, 32'h1);
        rdchk("R4 write 1 clears", 8'h14, 32'h0);
        pins("R5 irq drops", 1'b0, 1'b0);
        wr(8'h10, 32'h41);
        pulse_tick();
        rdchk("R3 re-assert while equal", 8'h14, 32'h1);
        wr(8'h14, 32'h7);
        wr(8'h10, 32'h40);
        pulse_tick();
        rdchk("R5 masked hit still latched", 8'h14, 32'h1);
        pins("R5 irq masked", 1'b0, 1'b0);
        wr(8'h14, 32'h7);
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_wake();
        wr(8'h0C, 32'd12);
        wr(8'h10, 32'h48);
        pulse_tick();
        rdchk("R6 status B and wake event", 8'h14, 32'h6);
        pins("R6 wake via B", 1'b0, 1'b1);
        wr(8'h14, 32'h7);
        pins("R6 wake off after clear", 1'b0, 1'b0);
        wr(8'h10, 32'h80);
        pins("R6 forced wake", 1'b0, 1'b1);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0);
    endtask

    task automatic t_swclear();
        wr(8'h10, 32'h41);
        wr(8'h08, 32'd12);
        pulse_tick();
        wr(8'h10, 32'h10);
        pulse_tick();
        rdchk("R7 up cleared", 8'h00, 32'h0);
        rdchk("R7 down cleared", 8'h04, 32'h0);
        rdchk("R7 status cleared", 8'h14, 32'h0);
        wr(8'h10, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_key_reset();
        wr(8'h18, 32'hB5C1_3F27);
        rdchk("R8 marker readback", 8'h18, 32'hB5C1_3F27);
        wr(8'h10, 32'h41);
        wr(8'h00, 32'd77);
        wr(8'h08, 32'd77);
        wr(8'h8C, 32'hCAFE_0003);
        pulse_tick();
        rdchk("R9 pre-reset status", 8'h14, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rdchk("R9 ctrl cleared", 8'h10, 32'h0);
        rdchk("R9 status cleared", 8'h14, 32'h0);
        rdchk("R9 up kept", 8'h00, 32'd77);
        rdchk("R9 compare kept", 8'h08, 32'd77);
        rdchk("R9 marker kept", 8'h18, 32'hB5C1_3F27);
        rdchk("R9 scratch kept", 8'h8C, 32'hCAFE_0003);
        wr(8'h08, 32'hFFFF_FFFF);
    endtask

    task automatic t_scratch();
        for (int i = 0; i < 32; i++) wr(8'(8'h80 + 4 * i), 32'(i) * 32'h0101_0101 ^ 32'hA5A5_5A5A);
        for (int i = 0; i < 32; i++)
            rdchk($sformatf("R10 scratch word %0d", i), 8'(8'h80 + 4 * i),
                  32'(i) * 32'h0101_0101 ^ 32'hA5A5_5A5A);
    endtask

    task automatic t_unmapped();
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h40, 32'h1234_5678);
        rdchk("R11 0x1C reads zero", 8'h1C, 32'h0);
        rdchk("R11 0x40 reads zero", 8'h40, 32'h0);
        rdchk("R11 marker untouched", 8'h18, 32'hB5C1_3F27);
        rdchk("R11 up untouched", 8'h00, 32'd77);
        wr(8'h10, 32'hFF);
        rdchk("R11 ctrl bit5 absent", 8'h10, 32'hDF);
        wr(8'h10, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_count();
        t_wrap();
        t_match_irq();
        t_wake();
        t_swclear();
        t_key_reset();
        t_scratch();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule